// File: doc/BRIEF.md
# Work-RAM Bank Controller

This block steers every CPU access aimed at battery-backed work RAM. An access comes either through the fixed 8K window at 6000-7FFF, whose bank number is held in a bank register inside this block, or from the program-ROM mapper, which supplies its own 3-bit RAM bank number. The block turns that 3-bit number into chip selects for up to two RAM chips and a 2-bit bank inside the chosen chip. The decode depends on how the board is populated: one 8K chip, two 8K chips, or one 32K chip. A bank number with no chip behind it raises an open-bus flag for the read data path, and no chip is selected.

The block also holds a pair of write-protect key registers. A RAM write strobe reaches the chips only when both keys hold their unlock values, the access selects a chip, and the CPU is writing, all in the same cycle. Reads work whatever the key state. Reset clears both keys, so software has to unlock the RAM again after every power-up.

Top module: `wram_bank_ctrl`

## Requirements
- R1: Reset clears both key registers and the window bank register. After reset a window write to bank 0 selects chip 0 but keeps `ram_we` low.
- R2: A register write to address 16'h5113 stores `reg_wdata[2:0]` as the window bank, and bits 7:3 are ignored. Window accesses (`acc_use_window`=1) use the stored value from the cycle after the write.
- R3: With `board_cfg`=2'd0 (one 8K chip), bank numbers 0-3 give `ram_cs`=2'b01 and `ram_bank`=0. Numbers 4-7 give `ram_cs`=0 and `open_bus`=1.
- R4: With `board_cfg`=2'd1 (two 8K chips), bank numbers 0-3 give `ram_cs`=2'b01 and numbers 4-7 give `ram_cs`=2'b10, both with `ram_bank`=0 and `open_bus`=0.
- R5: With `board_cfg`=2'd2 (one 32K chip), bank numbers 0-3 give `ram_cs`=2'b01 and `ram_bank` equal to the low two bits of the number. Numbers 4-7 give `ram_cs`=0, `ram_bank`=0 and `open_bus`=1.
- R6: `board_cfg`=2'd3 means no RAM is fitted. Every valid access gives `ram_cs`=0 and `open_bus`=1.
- R7: With `acc_use_window`=0, the decode uses `acc_bank` in place of the window bank and follows the same rules (R3-R6).
- R8: `ram_we` is 1 exactly when `acc_valid`, `acc_write`, a nonzero `ram_cs`, key A bits 1:0 = 2'b10 and key B bits 1:0 = 2'b01 all hold in the same cycle. Key A is written at 16'h5102 and key B at 16'h5103. Only bits 1:0 of each key are compared.
- R9: An open-bus access never asserts `ram_we`. A read, or a write while locked, still drives the chip selects.
- R10: With `acc_valid`=0, `ram_cs`, `ram_bank`, `open_bus` and `ram_we` are all 0.
- R11: Register writes to any other address, and cycles with `reg_we`=0, leave the window bank and both keys unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | CPU register write strobe |
| reg_addr | input | 16 | CPU register write address |
| reg_wdata | input | 8 | CPU register write data |
| board_cfg | input | 2 | Board population: 0 one 8K, 1 two 8K, 2 one 32K, 3 none |
| acc_valid | input | 1 | A RAM access is in progress |
| acc_use_window | input | 1 | 1: use the window bank register, 0: use acc_bank |
| acc_bank | input | 3 | RAM bank number requested by the program mapper |
| acc_write | input | 1 | CPU write strobe for the RAM access |
| ram_cs | output | 2 | One-hot chip selects, bit 0 is the first chip |
| ram_bank | output | 2 | Bank inside the selected chip |
| open_bus | output | 1 | The access hits no chip, so the data path floats |
| ram_we | output | 1 | Gated RAM write enable |

## Verification
The assertions assume that every input is driven to a known level from the first clock edge, and that `board_cfg` stays steady while an access is in progress. The bench meets both: it drives every input at time zero and changes inputs only on falling edges. It sets `board_cfg` only while `acc_valid` is low or before it starts a new probe. The checker builds its own copy of the key state from register writes seen at the ports, so it relies on keys being written only through `reg_we` with a settled address.

// File: rtl/wram_pkg.sv
package wram_pkg;

    localparam int WIN_BANK_W  = 3;
    localparam int CHIP_CNT    = 2;
    localparam int CHIP_IDX_W  = $clog2(CHIP_CNT);
    localparam int CHIP_BANK_W = 2;
    localparam int KEY_W       = 2;
    localparam int REG_ADDR_W  = 16;
    localparam int REG_DATA_W  = 8;

    localparam logic [REG_ADDR_W-1:0] ADDR_KEY_A  = 16'h5102;
    localparam logic [REG_ADDR_W-1:0] ADDR_KEY_B  = 16'h5103;
    localparam logic [REG_ADDR_W-1:0] ADDR_WINDOW = 16'h5113;

    localparam logic [KEY_W-1:0] UNLOCK_A = 2'b10;
    localparam logic [KEY_W-1:0] UNLOCK_B = 2'b01;

    typedef enum logic [1:0] {
        BOARD_ONE_8K  = 2'd0,
        BOARD_TWO_8K  = 2'd1,
        BOARD_ONE_32K = 2'd2,
        BOARD_EMPTY   = 2'd3
    } board_e;

    typedef struct packed {
        logic                   hit;
        logic [CHIP_IDX_W-1:0]  chip;
        logic [CHIP_BANK_W-1:0] sub;
    } bank_map_t;

    typedef struct packed {
        logic [WIN_BANK_W-1:0] win_bank;
        logic [KEY_W-1:0]      key_a;
        logic [KEY_W-1:0]      key_b;
    } wram_regs_t;

    // The top bit of the bank number picks the upper half of the 64K space.
    function automatic bank_map_t map_bank(board_e board, logic [WIN_BANK_W-1:0] num);
        bank_map_t m;
        logic      upper;
        upper  = num[WIN_BANK_W-1];
        m.hit  = 1'b0;
        m.chip = '0;
        m.sub  = '0;
        case (board)
            BOARD_ONE_8K: begin
                m.hit = !upper;
            end
            BOARD_TWO_8K: begin
                m.hit  = 1'b1;
                m.chip = CHIP_IDX_W'(upper);
            end
            BOARD_ONE_32K: begin
                m.hit = !upper;
                m.sub = num[CHIP_BANK_W-1:0];
            end
            default: begin
                m.hit = 1'b0;
            end
        endcase
        return m;
    endfunction

    function automatic logic keys_open(logic [KEY_W-1:0] a, logic [KEY_W-1:0] b);
        return (a == UNLOCK_A) && (b == UNLOCK_B);
    endfunction

endpackage

// File: rtl/wram_regfile.sv
module wram_regfile
    import wram_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [WIN_BANK_W-1:0] wdata_lo,
    output logic [WIN_BANK_W-1:0] win_bank,
    output logic                  unlocked
);

    wram_regs_t regs_q;
    wram_regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (reg_we) begin
            case (reg_addr)
                ADDR_KEY_A:  regs_d.key_a    = wdata_lo[KEY_W-1:0];
                ADDR_KEY_B:  regs_d.key_b    = wdata_lo[KEY_W-1:0];
                ADDR_WINDOW: regs_d.win_bank = wdata_lo;
                default:     regs_d          = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign win_bank = regs_q.win_bank;
    assign unlocked = keys_open(regs_q.key_a, regs_q.key_b);

endmodule

// File: rtl/wram_bank_decode.sv
module wram_bank_decode
    import wram_pkg::*;
(
    input  logic                   valid,
    input  board_e                 board,
    input  logic [WIN_BANK_W-1:0]  bank_num,
    output logic [CHIP_CNT-1:0]    chip_sel,
    output logic [CHIP_BANK_W-1:0] chip_bank,
    output logic                   float_bus
);

    bank_map_t map;

    always_comb begin
        map = map_bank(board, bank_num);
    end

    for (genvar i = 0; i < CHIP_CNT; i++) begin : g_sel
        assign chip_sel[i] = valid && map.hit && (map.chip == CHIP_IDX_W'(i));
    end

    assign chip_bank = (valid && map.hit) ? map.sub : '0;
    assign float_bus = valid && !map.hit;

endmodule

// File: rtl/wram_write_gate.sv
module wram_write_gate
    import wram_pkg::*;
(
    input  logic                valid,
    input  logic                cpu_write,
    input  logic [CHIP_CNT-1:0] chip_sel,
    input  logic                unlocked,
    output logic                write_en
);

    assign write_en = valid && cpu_write && (|chip_sel) && unlocked;

endmodule

// File: rtl/wram_bank_ctrl.sv
module wram_bank_ctrl
    import wram_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [15:0] reg_addr,
    input  logic [7:0]  reg_wdata,
    input  logic [1:0]  board_cfg,
    input  logic        acc_valid,
    input  logic        acc_use_window,
    input  logic [2:0]  acc_bank,
    input  logic        acc_write,
    output logic [1:0]  ram_cs,
    output logic [1:0]  ram_bank,
    output logic        open_bus,
    output logic        ram_we
);

    logic [WIN_BANK_W-1:0] win_bank;
    logic [WIN_BANK_W-1:0] sel_bank;
    logic                  unlocked;
    logic                  unused_wdata_hi;
    board_e                board;

    assign unused_wdata_hi = ^reg_wdata[REG_DATA_W-1:WIN_BANK_W];
    assign board           = board_e'(board_cfg);
    assign sel_bank        = acc_use_window ? win_bank : acc_bank;

    wram_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .wdata_lo (reg_wdata[WIN_BANK_W-1:0]),
        .win_bank (win_bank),
        .unlocked (unlocked)
    );

    wram_bank_decode u_decode (
        .valid     (acc_valid),
        .board     (board),
        .bank_num  (sel_bank),
        .chip_sel  (ram_cs),
        .chip_bank (ram_bank),
        .float_bus (open_bus)
    );

    wram_write_gate u_gate (
        .valid     (acc_valid),
        .cpu_write (acc_write),
        .chip_sel  (ram_cs),
        .unlocked  (unlocked),
        .write_en  (ram_we)
    );

endmodule

// File: rtl/wram_bank_ctrl_chk.sv
module wram_bank_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic [15:0] reg_addr,
    input logic [7:0]  reg_wdata,
    input logic [1:0]  board_cfg,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [1:0]  ram_cs,
    input logic [1:0]  ram_bank,
    input logic        open_bus,
    input logic        ram_we
);

    // Key state rebuilt from the register write bus alone.
    logic [1:0] shadow_a;
    logic [1:0] shadow_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_a <= 2'b00;
            shadow_b <= 2'b00;
        end else if (reg_we) begin
            if (reg_addr == 16'h5102) shadow_a <= reg_wdata[1:0];
            if (reg_addr == 16'h5103) shadow_b <= reg_wdata[1:0];
        end
    end

    p_cs_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ram_cs));

    p_float_no_cs_r9: assert property (@(posedge clk) disable iff (rst)
        open_bus |-> (ram_cs == 2'b00) && !ram_we);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> (ram_cs == 2'b00) && (ram_bank == 2'b00) && !open_bus && !ram_we);

    p_empty_board_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && board_cfg == 2'd3) |-> open_bus);

    p_small_chip_bank_r3: assert property (@(posedge clk) disable iff (rst)
        (board_cfg == 2'd0 || board_cfg == 2'd1) |-> (ram_bank == 2'b00));

    p_relock_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !ram_we);

    p_we_matches_key_r8: assert property (@(posedge clk) disable iff (rst)
        ram_we == (acc_valid && acc_write && (ram_cs != 2'b00)
                   && shadow_a == 2'b10 && shadow_b == 2'b01));

    p_valid_decides_r7: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> ((ram_cs != 2'b00) != open_bus));

endmodule

bind wram_bank_ctrl wram_bank_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .board_cfg (board_cfg),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .ram_cs    (ram_cs),
    .ram_bank  (ram_bank),
    .open_bus  (open_bus),
    .ram_we    (ram_we)
);

// File: tb/wram_bank_ctrl_tb.sv
module wram_bank_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [15:0] reg_addr = 16'h0000;
    logic [7:0]  reg_wdata = 8'h00;
    logic [1:0]  board_cfg = 2'd0;
    logic        acc_valid = 1'b0;
    logic        acc_use_window = 1'b0;
    logic [2:0]  acc_bank = 3'd0;
    logic        acc_write = 1'b0;
    logic [1:0]  ram_cs;
    logic [1:0]  ram_bank;
    logic        open_bus;
    logic        ram_we;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wram_bank_ctrl u_dut (
        .clk            (clk),
        .rst            (rst),
        .reg_we         (reg_we),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .board_cfg      (board_cfg),
        .acc_valid      (acc_valid),
        .acc_use_window (acc_use_window),
        .acc_bank       (acc_bank),
        .acc_write      (acc_write),
        .ram_cs         (ram_cs),
        .ram_bank       (ram_bank),
        .open_bus       (open_bus),
        .ram_we         (ram_we)
    );

    // Packed result: {cs[1:0], bank[1:0], open_bus, we}
    function automatic logic [5:0] spec_decode(logic [1:0] cfg, logic [2:0] n,
                                               logic wr, logic unlk);
        logic [1:0] cs;
        logic [1:0] bk;
        logic       ob;
        cs = 2'b00; bk = 2'b00; ob = 1'b0;
        case (cfg)
            2'd0: if (n < 3'd4) cs = 2'b01; else ob = 1'b1;
            2'd1: cs = (n < 3'd4) ? 2'b01 : 2'b10;
            2'd2: if (n < 3'd4) begin cs = 2'b01; bk = n[1:0]; end else ob = 1'b1;
            default: ob = 1'b1;
        endcase
        return {cs, bk, ob, wr && unlk && (cs != 2'b00)};
    endfunction

    task automatic compare(string tag, logic [5:0] exp);
        logic [5:0] act;
        act = {ram_cs, ram_bank, open_bus, ram_we};
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got cs/bank/ob/we=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic reg_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 16'h0000; reg_wdata = 8'h00;
    endtask

    task automatic probe(logic [1:0] cfg, logic win, logic [2:0] n, logic wr);
        @(negedge clk);
        board_cfg = cfg; acc_valid = 1'b1; acc_use_window = win;
        acc_bank = n; acc_write = wr;
        #2;
    endtask

    task automatic idle_bus();
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_use_window = 1'b0; acc_bank = 3'd0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        apply_reset();
        probe(2'd2, 1'b1, 3'd0, 1'b1);
        compare("R1 reset locked, window bank 0", spec_decode(2'd2, 3'd0, 1'b1, 1'b0));
        idle_bus();
    endtask

    task automatic t_window_register();
        reg_write(16'h5113, 8'hFB);
        probe(2'd2, 1'b1, 3'd6, 1'b0);
        compare("R2 window bank low bits only", spec_decode(2'd2, 3'd3, 1'b0, 1'b0));
        reg_write(16'h5113, 8'h0C);
        probe(2'd2, 1'b1, 3'd0, 1'b0);
        compare("R5 window bank 4 on 32K open", spec_decode(2'd2, 3'd4, 1'b0, 1'b0));
        probe(2'd1, 1'b1, 3'd0, 1'b0);
        compare("R4 window bank 4 on two chips", spec_decode(2'd1, 3'd4, 1'b0, 1'b0));
        idle_bus();
    endtask

    task automatic t_board_sweep();
        string tags[4];
        tags[0] = "R3 one 8K"; tags[1] = "R4 two 8K";
        tags[2] = "R5 one 32K"; tags[3] = "R6 empty board";
        for (int c = 0; c < 4; c++) begin
            for (int b = 0; b < 8; b++) begin
                probe(2'(c), 1'b0, 3'(b), 1'b0);
                compare($sformatf("%s R7 mapper bank %0d", tags[c], b),
                        spec_decode(2'(c), 3'(b), 1'b0, 1'b0));
            end
        end
        idle_bus();
    endtask

    task automatic t_unlock();
        reg_write(16'h5102, 8'h02);
        probe(2'd1, 1'b0, 3'd5, 1'b1);
        compare("R8 half key stays locked", spec_decode(2'd1, 3'd5, 1'b1, 1'b0));
        reg_write(16'h5103, 8'h01);
        probe(2'd1, 1'b0, 3'd5, 1'b1);
        compare("R8 full key unlocks", spec_decode(2'd1, 3'd5, 1'b1, 1'b1));
        probe(2'd1, 1'b0, 3'd2, 1'b0);
        compare("R8 read with key set", spec_decode(2'd1, 3'd2, 1'b0, 1'b1));
        probe(2'd0, 1'b0, 3'd6, 1'b1);
        compare("R9 open bus write dropped", spec_decode(2'd0, 3'd6, 1'b1, 1'b1));
        probe(2'd3, 1'b0, 3'd1, 1'b1);
        compare("R9 empty board write dropped", spec_decode(2'd3, 3'd1, 1'b1, 1'b1));
        reg_write(16'h5103, 8'h00);
        probe(2'd2, 1'b0, 3'd3, 1'b1);
        compare("R9 locked write keeps chip select", spec_decode(2'd2, 3'd3, 1'b1, 1'b0));
        reg_write(16'h5102, 8'hFE);
        reg_write(16'h5103, 8'h5D);
        probe(2'd2, 1'b0, 3'd1, 1'b1);
        compare("R8 upper key bits ignored", spec_decode(2'd2, 3'd1, 1'b1, 1'b1));
        reg_write(16'h5102, 8'h03);
        probe(2'd2, 1'b0, 3'd1, 1'b1);
        compare("R8 wrong low bits lock", spec_decode(2'd2, 3'd1, 1'b1, 1'b0));
        reg_write(16'h5102, 8'h02);
        idle_bus();
    endtask

    task automatic t_idle();
        @(negedge clk);
        board_cfg = 2'd1; acc_valid = 1'b0; acc_use_window = 1'b0;
        acc_bank = 3'd5; acc_write = 1'b1;
        #2;
        compare("R10 idle outputs quiet", 6'b000000);
        idle_bus();
    endtask

    task automatic t_other_addresses();
        reg_write(16'h5113, 8'h02);
        reg_write(16'h5112, 8'h05);
        reg_write(16'h7113, 8'h06);
        reg_write(16'h5104, 8'h00);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 16'h5113; reg_wdata = 8'h07;
        @(negedge clk);
        reg_addr = 16'h5103; reg_wdata = 8'h00;
        @(negedge clk);
        reg_addr = 16'h0000; reg_wdata = 8'h00;
        probe(2'd2, 1'b1, 3'd0, 1'b1);
        compare("R11 foreign writes ignored", spec_decode(2'd2, 3'd2, 1'b1, 1'b1));
        idle_bus();
    endtask

    task automatic t_reset_relock();
        apply_reset();
        probe(2'd2, 1'b1, 3'd0, 1'b1);
        compare("R1 reset clears key and window", spec_decode(2'd2, 3'd0, 1'b1, 1'b0));
        idle_bus();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset_state();
        t_window_register();
        t_board_sweep();
        t_unlock();
        t_idle();
        t_other_addresses();
        t_reset_relock();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule